// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is a single-buffered serial master. A host places one word at a time into a transmit holding register together with per-word control bits: which chip-select line to drive, whether that line stays asserted after the word, and whether an idle gap follows the word. The engine latches the live format inputs when it starts a word. These inputs set the clock divider, the idle clock level, the launch phase, the bit order, the word length, optional parity, the setup and hold delays around the data and the gap length. It then shifts the word out while capturing the return line into a receive register.

The receive side holds one word. The host pops it with a read strobe. Parity mismatches and words lost to an unread receive register are latched as sticky error flags until an explicit clear. A loopback input routes the serial output back to the capture path so the whole data path can be exercised without a peripheral. All timing is counted in module clock cycles. MIN_PRESCALE must be at least 2, which guarantees the capture point falls strictly inside each bit period.

Top module: `spi_xfer_engine`

## Requirements
- R1: After reset every chip-select output is high, the serial clock is low, and the status word reads 0x8000_0000 (receive register empty, nothing pending, no errors).
- R2: Each word is sent in the configured order: MSB first when the bit-order input is 0, LSB first when it is 1. With loopback set, the received word equals the sent word masked to the word length, for any length from 2 to 16 bits. Unused upper bits read as zero.
- R3: For each word, exactly the selected chip-select line goes low, one cycle after the word is accepted. It stays low for (lead+1) + N*(prescale+1) + (lag+1) cycles, where N is the word length plus one when parity is on. The serial clock makes exactly 2N transitions in that window, and no more than one chip-select line is ever low.
- R4: When a word was written with the hold bit set, its chip-select line stays low after the word ends. Otherwise all lines return high in the cycle after the window of R3.
- R5: Outside the shifting phase the serial clock sits at the polarity input. In the first shifting cycle it is idle when the phase input is 1 (data launched before the first edge) and active when the phase input is 0.
- R6: With the timer-disable input set, the lead and lag delays are ignored and count as zero.
- R7: Between two back-to-back words that release chip select, the lines stay high for 1 cycle without a gap. When the first word carried the gap-enable bit, they stay high for gap+2 cycles.
- R8: With parity on, one parity bit follows the data bits. Even parity sends the XOR of the data bits; odd parity sends its complement. A received parity bit that disagrees sets status bit 2, which stays set until the error-clear input.
- R9: When a word completes while the receive register is still full and no read is made in that cycle, status bit 6 is set and stays set until error-clear. The newest word replaces the old one.
- R10: While the prescale input is below MIN_PRESCALE or the word length is outside 2..16, a pending word is not started and the chip-select lines stay high. A write while a word is pending is ignored.
- R11: Status bit 31 is set while the receive register is empty and is cleared only by a completed word. Bit 29 is set while a word is pending. A read strobe empties the receive register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_prescale | input | 8 | Bit period minus one, in module cycles |
| cfg_wlen | input | 5 | Data bits per word (2..16) |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_phase | input | 1 | 1: launch before first edge; 0: launch on first edge |
| cfg_lsb_first | input | 1 | 1: LSB first; 0: MSB first |
| cfg_par_en | input | 1 | Append a parity bit |
| cfg_par_odd | input | 1 | 1: odd parity; 0: even parity |
| cfg_gap | input | 6 | Inter-word gap length |
| cfg_lead | input | 8 | Chip-select-to-data delay |
| cfg_lag | input | 8 | Data-to-chip-select-release delay |
| cfg_timer_off | input | 1 | Ignore lead and lag |
| loopback | input | 1 | Capture the serial output instead of miso |
| wr_en | input | 1 | Write strobe for a word |
| wr_data | input | DATA_W | Word to send |
| wr_hold | input | 1 | Keep chip select low after this word |
| wr_gap_en | input | 1 | Insert the gap after this word |
| wr_cs | input | CS_IDX_W | Index of the chip-select line |
| rd_en | input | 1 | Pop the receive register |
| err_clr | input | 1 | Clear the sticky error flags |
| rd_data | output | DATA_W | Last received word |
| status | output | 32 | Flags: 31 rx empty, 29 tx pending, 6 overrun, 2 parity |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | CS_W | Active-low chip selects |

## Verification
The sticky-flag and receive-register properties assume the host drives error-clear and read only as single strobes. The idle-clock property assumes the polarity input is held steady for a cycle before it is compared. The stimulus never changes any format input while a word is in flight: it reconfigures only after a word has fully finished and its result has been read. The parity-error case drives miso to a constant with loopback off, so the received parity bit is known in advance.

// File: rtl/spi_xe_pkg.sv
package spi_xe_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SHIFT,
    ST_HOLD,
    ST_GAP
  } xe_state_e;

  typedef struct packed {
    logic [7:0] prescale;
    logic [4:0] wlen;
    logic       cpol;
    logic       phase;
    logic       lsb_first;
    logic       par_en;
    logic       par_odd;
    logic [5:0] gap;
    logic [7:0] lead;
    logic [7:0] lag;
    logic       timer_off;
  } xe_fmt_t;

  // XOR of the low n bits, inverted for odd parity
  function automatic logic word_parity(input logic [31:0] w, input logic [4:0] n,
                                       input logic odd);
    logic acc;
    acc = odd;
    for (int i = 0; i < 32; i++) begin
      if (i < int'(n)) acc = acc ^ w[i];
    end
    return acc;
  endfunction

endpackage

// File: rtl/spi_xe_bitsel.sv
module spi_xe_bitsel import spi_xe_pkg::*; #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] word,
  input  logic [4:0]        wlen,
  input  logic              lsb_first,
  input  logic              par_odd,
  input  logic [4:0]        idx,
  output logic              bit_out
);
  logic [4:0] pos;

  always_comb begin
    pos     = lsb_first ? idx : (wlen - 5'd1 - idx);
    bit_out = word_parity(32'(word), wlen, par_odd);
    if (idx < wlen) begin
      for (int i = 0; i < DATA_W; i++) begin
        if (5'(i) == pos) bit_out = word[i];
      end
    end
  end
endmodule

// File: rtl/spi_xe_rxbuf.sv
module spi_xe_rxbuf #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  logic [DATA_W-1:0] word_in,
  input  logic              par_bad,
  input  logic              rd_en,
  input  logic              err_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              ovr_err,
  output logic              par_err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data <= '0;
      rx_full <= 1'b0;
      ovr_err <= 1'b0;
      par_err <= 1'b0;
    end else begin
      if (err_clr) begin
        ovr_err <= 1'b0;
        par_err <= 1'b0;
      end
      if (rd_en) rx_full <= 1'b0;
      if (done) begin
        rx_data <= word_in;
        rx_full <= 1'b1;
        if (rx_full && !rd_en) ovr_err <= 1'b1;
        if (par_bad) par_err <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine import spi_xe_pkg::*; #(
  parameter int DATA_W       = 16,
  parameter int CS_W         = 8,
  parameter int MIN_PRESCALE = 2,
  localparam int CS_IDX_W    = (CS_W > 1) ? $clog2(CS_W) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [7:0]          cfg_prescale,
  input  logic [4:0]          cfg_wlen,
  input  logic                cfg_cpol,
  input  logic                cfg_phase,
  input  logic                cfg_lsb_first,
  input  logic                cfg_par_en,
  input  logic                cfg_par_odd,
  input  logic [5:0]          cfg_gap,
  input  logic [7:0]          cfg_lead,
  input  logic [7:0]          cfg_lag,
  input  logic                cfg_timer_off,
  input  logic                loopback,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                wr_hold,
  input  logic                wr_gap_en,
  input  logic [CS_IDX_W-1:0] wr_cs,
  input  logic                rd_en,
  input  logic                err_clr,
  output logic [DATA_W-1:0]   rd_data,
  output logic [31:0]         status,
  output logic                sck,
  output logic                mosi,
  input  logic                miso,
  output logic [CS_W-1:0]     cs_n
);
  xe_fmt_t live_fmt, cur;
  xe_state_e state;

  logic                cfg_ok;
  logic [DATA_W-1:0]   tx_word, cur_word, rx_word, rx_next;
  logic                tx_hold, tx_gapen, tx_full, cur_hold, cur_gapen;
  logic [CS_IDX_W-1:0] tx_cs;
  logic [CS_W-1:0]     cs_pick_n, cs_r;
  logic [7:0]          cnt, lead_eff, lag_eff;
  logic [4:0]          bitn;
  logic [8:0]          half, cnt_nx9;
  logic [5:0]          nbits;
  logic                last_bit, cnt_end, sample, done, miso_eff, tx_bit, rx_par, rx_par_bad;
  logic                sck_r, mosi_r, rx_full, ovr_err, par_err;

  assign live_fmt = '{prescale: cfg_prescale, wlen: cfg_wlen, cpol: cfg_cpol,
                      phase: cfg_phase, lsb_first: cfg_lsb_first, par_en: cfg_par_en,
                      par_odd: cfg_par_odd, gap: cfg_gap, lead: cfg_lead, lag: cfg_lag,
                      timer_off: cfg_timer_off};

  assign cfg_ok = (cfg_prescale >= 8'(MIN_PRESCALE)) && (cfg_wlen >= 5'd2) &&
                  ({1'b0, cfg_wlen} <= 6'(DATA_W));

  // one-cold decode of the pending word's select index
  for (genvar g = 0; g < CS_W; g++) begin : g_csdec
    assign cs_pick_n[g] = (tx_cs != CS_IDX_W'(g));
  end

  assign lead_eff   = cur.timer_off ? 8'd0 : cur.lead;
  assign lag_eff    = cur.timer_off ? 8'd0 : cur.lag;
  assign half       = ({1'b0, cur.prescale} + 9'd1) >> 1;
  assign cnt_nx9    = {1'b0, cnt} + 9'd1;
  assign nbits      = {1'b0, cur.wlen} + {5'd0, cur.par_en};
  assign last_bit   = ({1'b0, bitn} == nbits - 6'd1);
  assign cnt_end    = (cnt == cur.prescale);
  assign sample     = (state == ST_SHIFT) && ({1'b0, cnt} == half);
  assign done       = (state == ST_SHIFT) && cnt_end && last_bit;
  assign miso_eff   = loopback ? mosi_r : miso;
  assign rx_par_bad = cur.par_en &&
                      (rx_par != word_parity(32'(rx_word), cur.wlen, cur.par_odd));

  // capture path: MSB-first shifts up from bit 0, LSB-first shifts down from bit wlen-1
  always_comb begin
    if (cur.lsb_first) begin
      rx_next = rx_word >> 1;
      for (int i = 0; i < DATA_W; i++) begin
        if (5'(i) == cur.wlen - 5'd1) rx_next[i] = miso_eff;
      end
    end else begin
      rx_next    = rx_word << 1;
      rx_next[0] = miso_eff;
    end
  end

  spi_xe_bitsel #(.DATA_W(DATA_W)) u_bitsel (
    .word(cur_word), .wlen(cur.wlen), .lsb_first(cur.lsb_first),
    .par_odd(cur.par_odd), .idx(bitn), .bit_out(tx_bit)
  );

  spi_xe_rxbuf #(.DATA_W(DATA_W)) u_rxbuf (
    .clk(clk), .rst(rst), .done(done), .word_in(rx_word), .par_bad(rx_par_bad),
    .rd_en(rd_en), .err_clr(err_clr), .rx_data(rd_data), .rx_full(rx_full),
    .ovr_err(ovr_err), .par_err(par_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cur       <= '0;
      cur_word  <= '0;
      cur_hold  <= 1'b0;
      cur_gapen <= 1'b0;
      tx_word   <= '0;
      tx_hold   <= 1'b0;
      tx_gapen  <= 1'b0;
      tx_cs     <= '0;
      tx_full   <= 1'b0;
      cnt       <= '0;
      bitn      <= '0;
      rx_word   <= '0;
      rx_par    <= 1'b0;
      cs_r      <= '1;
      sck_r     <= 1'b0;
      mosi_r    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          sck_r <= cfg_cpol;
          if (tx_full && cfg_ok) begin
            cur       <= live_fmt;
            cur_word  <= tx_word;
            cur_hold  <= tx_hold;
            cur_gapen <= tx_gapen;
            cs_r      <= cs_pick_n;
            tx_full   <= 1'b0;
            cnt       <= '0;
            bitn      <= '0;
            rx_word   <= '0;
            rx_par    <= 1'b0;
            state     <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (cnt == lead_eff) begin
            cnt    <= '0;
            sck_r  <= cur.cpol ^ ~cur.phase;
            mosi_r <= tx_bit;
            state  <= ST_SHIFT;
          end else begin
            cnt   <= cnt + 8'd1;
            sck_r <= cur.cpol;
          end
        end
        ST_SHIFT: begin
          if (cnt == 8'd0) mosi_r <= tx_bit;
          if (sample) begin
            if (bitn < cur.wlen) rx_word <= rx_next;
            else                 rx_par  <= miso_eff;
          end
          if (cnt_end) begin
            cnt <= '0;
            if (last_bit) begin
              sck_r <= cur.cpol;
              state <= ST_HOLD;
            end else begin
              bitn  <= bitn + 5'd1;
              sck_r <= cur.cpol ^ ~cur.phase;
            end
          end else begin
            cnt   <= cnt + 8'd1;
            sck_r <= cur.cpol ^ (cur.phase ? (cnt_nx9 >= half) : (cnt_nx9 < half));
          end
        end
        ST_HOLD: begin
          sck_r <= cur.cpol;
          if (cnt == lag_eff) begin
            cnt <= '0;
            if (!cur_hold) cs_r <= '1;
            state <= cur_gapen ? ST_GAP : ST_IDLE;
          end else begin
            cnt <= cnt + 8'd1;
          end
        end
        ST_GAP: begin
          sck_r <= cfg_cpol;
          if (cnt == {2'b00, cur.gap}) begin
            cnt   <= '0;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + 8'd1;
          end
        end
        default: state <= ST_IDLE;
      endcase

      if (wr_en && !tx_full) begin
        tx_word  <= wr_data;
        tx_hold  <= wr_hold;
        tx_gapen <= wr_gap_en;
        tx_cs    <= wr_cs;
        tx_full  <= 1'b1;
      end
    end
  end

  always_comb begin
    status     = '0;
    status[31] = ~rx_full;
    status[29] = tx_full;
    status[6]  = ovr_err;
    status[2]  = par_err;
  end

  assign sck  = sck_r;
  assign mosi = mosi_r;
  assign cs_n = cs_r;
endmodule

// File: rtl/spi_xfer_engine_chk.sv
module spi_xfer_engine_chk #(
  parameter int CS_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic [CS_W-1:0] cs_n,
  input logic            sck,
  input logic            cfg_cpol,
  input logic [31:0]     status,
  input logic            rd_en,
  input logic            err_clr,
  input logic            wr_en
);
  // R3
  cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));

  // R5
  sck_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (&cs_n && &$past(cs_n) && !$past(rst) && $stable(cfg_cpol)) |-> (sck == cfg_cpol));

  // R8
  perr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (status[2] && !err_clr) |=> status[2]);

  // R9
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (status[6] && !err_clr) |=> status[6]);

  // R11
  rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!status[31] && !rd_en) |=> !status[31]);

  // R11
  tx_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (!status[29] && wr_en) |=> status[29]);
endmodule

bind spi_xfer_engine spi_xfer_engine_chk #(.CS_W(CS_W)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .cfg_cpol(cfg_cpol),
  .status(status), .rd_en(rd_en), .err_clr(err_clr), .wr_en(wr_en)
);

// File: tb/test_spi_xfer_engine.sv
`timescale 1ns/1ps
module test_spi_xfer_engine;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [7:0]  c_prescale = 8'd3;
  logic [4:0]  c_wlen = 5'd8;
  logic        c_cpol = 1'b0, c_phase = 1'b1, c_lsb = 1'b0, c_par = 1'b0, c_odd = 1'b0;
  logic [5:0]  c_gap = 6'd0;
  logic [7:0]  c_lead = 8'd2, c_lag = 8'd1;
  logic        c_toff = 1'b0, lpbk = 1'b1;
  logic        wr_en = 1'b0, wr_hold = 1'b0, wr_gap_en = 1'b0, rd_en = 1'b0, err_clr = 1'b0;
  logic [15:0] wr_data = '0;
  logic [2:0]  wr_cs = '0;
  logic        miso = 1'b0;
  logic [15:0] rd_data;
  logic [31:0] status;
  logic        sck, mosi;
  logic [7:0]  cs_n;

  int n_tests = 0, n_fail = 0, cyc = 0;
  logic [15:0] exp_q[$];

  spi_xfer_engine i_spi_xfer_engine (
    .clk(clk), .rst(rst), .cfg_prescale(c_prescale), .cfg_wlen(c_wlen), .cfg_cpol(c_cpol),
    .cfg_phase(c_phase), .cfg_lsb_first(c_lsb), .cfg_par_en(c_par), .cfg_par_odd(c_odd),
    .cfg_gap(c_gap), .cfg_lead(c_lead), .cfg_lag(c_lag), .cfg_timer_off(c_toff),
    .loopback(lpbk), .wr_en(wr_en), .wr_data(wr_data), .wr_hold(wr_hold),
    .wr_gap_en(wr_gap_en), .wr_cs(wr_cs), .rd_en(rd_en), .err_clr(err_clr),
    .rd_data(rd_data), .status(status), .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mask(input logic [15:0] d, input int w);
    return d & 16'((32'd1 << w) - 1);
  endfunction

  function automatic int nbits();
    return int'(c_wlen) + (c_par ? 1 : 0);
  endfunction

  function automatic int lead_e();
    return c_toff ? 0 : int'(c_lead);
  endfunction

  function automatic int win_len();
    return (lead_e() + 1) + nbits() * (int'(c_prescale) + 1) + ((c_toff ? 0 : int'(c_lag)) + 1);
  endfunction

  task automatic pulse_rd();
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
  endtask

  // Behavioural per-cycle model of one word frame
  task automatic xfer(input logic [15:0] d, input bit hold, input int idx, input bit pop);
    int L, tog;
    logic psck;
    logic [7:0] lowpat;
    L = win_len();
    lowpat = ~(8'd1 << idx);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; wr_hold = hold; wr_gap_en = 1'b0; wr_cs = 3'(idx);
    @(negedge clk);
    wr_en = 1'b0;
    chk(status[29] == 1'b1, "R11 tx pending", status, 32'h2000_0000);
    tog = 0;
    psck = sck;
    for (int k = 1; k <= L; k++) begin
      @(negedge clk);
      chk(cs_n == lowpat, "R3 cs window", cs_n, lowpat);
      if (k <= lead_e() + 1) chk(sck == c_cpol, "R5 idle before data", sck, c_cpol);
      if (k == lead_e() + 2)
        chk(sck == (c_cpol ^ ~c_phase), "R5 first bit level", sck, c_cpol ^ ~c_phase);
      if (sck != psck) tog++;
      psck = sck;
    end
    @(negedge clk);
    if (hold) chk(cs_n == lowpat, "R4 cs held", cs_n, lowpat);
    else      chk(cs_n == 8'hFF, "R4 cs released", cs_n, 8'hFF);
    chk(tog == 2 * nbits(), "R3 clock transitions", tog, 2 * nbits());
    chk(status[31] == 1'b0, "R11 rx filled", status, 0);
    if (lpbk) chk(rd_data == mask(d, int'(c_wlen)), "R2 loopback data", rd_data, mask(d, int'(c_wlen)));
    if (pop) begin
      pulse_rd();
      chk(status[31] == 1'b1, "R11 rx popped", status, 32'h8000_0000);
    end
  endtask

  task automatic gap_pair(input bit gapen, input int exp_high);
    int hi, guard;
    @(negedge clk); wr_en = 1'b1; wr_data = 16'h3C; wr_hold = 1'b0; wr_gap_en = gapen; wr_cs = 3'd1;
    @(negedge clk); wr_en = 1'b0;
    repeat (3) @(negedge clk);
    wr_en = 1'b1; wr_data = 16'hC3; wr_gap_en = 1'b0;
    @(negedge clk); wr_en = 1'b0;
    guard = 0;
    while (cs_n != 8'hFF && guard < 1000) begin @(negedge clk); guard++; end
    hi = 0;
    while (cs_n == 8'hFF && guard < 1000) begin hi++; @(negedge clk); guard++; end
    chk(hi == exp_high, "R7 gap length", hi, exp_high);
    while (cs_n != 8'hFF && guard < 1000) begin @(negedge clk); guard++; end
    chk(rd_data == 16'hC3, "R9 newest kept", rd_data, 16'hC3);
    pulse_clr();
    pulse_rd();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_fail++;
        $display("FAIL watchdog: actual %0d expected <150000", cyc);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] pat;
    int lens[5] = '{2, 5, 8, 13, 16};
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(cs_n == 8'hFF, "R1 cs reset", cs_n, 8'hFF);
    chk(status == 32'h8000_0000, "R1 status reset", status, 32'h8000_0000);
    chk(sck == 1'b0, "R1 sck reset", sck, 0);

    // R2 R3 R5: all modes, orders and lengths
    for (int m = 0; m < 8; m++) begin
      c_cpol = m[0]; c_phase = m[1]; c_lsb = m[2];
      for (int j = 0; j < 5; j++) begin
        c_wlen = 5'(lens[j]);
        pat = 16'hA5C3 ^ 16'(m * 16'h1111) ^ 16'(j * 16'h0F0F);
        xfer(pat, 1'b0, (m + j) % 8, 1'b1);
      end
    end
    c_cpol = 1'b0; c_phase = 1'b1; c_lsb = 1'b0; c_wlen = 5'd8;

    // R6 timer disable
    c_lead = 8'd5; c_lag = 8'd7; c_toff = 1'b1;
    xfer(16'h5A, 1'b0, 3, 1'b1);
    c_toff = 1'b0; c_prescale = 8'd6;
    xfer(16'h96, 1'b0, 4, 1'b1);
    c_prescale = 8'd3; c_lead = 8'd2; c_lag = 8'd1;

    // R4 hold then release on the same line
    xfer(16'h11, 1'b1, 2, 1'b1);
    xfer(16'h22, 1'b0, 2, 1'b1);

    // R8 parity in loopback: both senses, no error
    c_par = 1'b1; c_odd = 1'b0;
    xfer(16'hB7, 1'b0, 5, 1'b1);
    c_odd = 1'b1;
    xfer(16'hB6, 1'b0, 6, 1'b1);
    chk(status[2] == 1'b0, "R8 no parity error", status, 0);

    // R8 mismatch: miso stuck at 1, 8 ones, even parity expects 0
    lpbk = 1'b0; miso = 1'b1; c_odd = 1'b0;
    xfer(16'h00, 1'b0, 0, 1'b0);
    chk(rd_data == 16'h00FF, "R8 stuck line data", rd_data, 16'h00FF);
    chk(status[2] == 1'b1, "R8 parity error set", status, 32'h4);
    pulse_clr();
    chk(status[2] == 1'b0, "R8 parity error cleared", status, 0);
    pulse_rd();
    c_odd = 1'b1;
    xfer(16'h00, 1'b0, 0, 1'b1);
    chk(status[2] == 1'b0, "R8 odd parity matches", status, 0);
    lpbk = 1'b1; miso = 1'b0; c_par = 1'b0; c_odd = 1'b0;

    // R9 overrun
    exp_q.push_back(16'h0F); exp_q.push_back(16'hF0);
    xfer(exp_q[0], 1'b0, 1, 1'b0);
    chk(status[6] == 1'b0, "R9 no overrun yet", status, 0);
    xfer(exp_q[1], 1'b0, 1, 1'b0);
    chk(status[6] == 1'b1, "R9 overrun set", status, 32'h40);
    chk(rd_data == exp_q[$], "R9 newest word", rd_data, exp_q[$]);
    pulse_clr();
    chk(status[6] == 1'b0, "R9 overrun cleared", status, 0);
    pulse_rd();

    // R7 inter-word gap
    c_gap = 6'd3;
    gap_pair(1'b1, 5);
    gap_pair(1'b0, 1);

    // R10 invalid prescale, then invalid length
    c_prescale = 8'd1;
    @(negedge clk); wr_en = 1'b1; wr_data = 16'h1234; wr_cs = 3'd0; wr_hold = 1'b0;
    @(negedge clk); wr_en = 1'b0;
    repeat (20) @(negedge clk);
    chk(cs_n == 8'hFF, "R10 no start on bad prescale", cs_n, 8'hFF);
    chk(status[29] == 1'b1, "R10 word still pending", status, 32'h2000_0000);
    wr_en = 1'b1; wr_data = 16'h5555;
    @(negedge clk); wr_en = 1'b0;
    c_prescale = 8'd3; c_wlen = 5'd17;
    repeat (20) @(negedge clk);
    chk(cs_n == 8'hFF, "R10 no start on bad length", cs_n, 8'hFF);
    c_wlen = 5'd16;
    repeat (120) @(negedge clk);
    chk(rd_data == 16'h1234, "R10 first word kept", rd_data, 16'h1234);
    chk(status[29] == 1'b0, "R10 nothing pending", status, 0);
    pulse_rd();

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule